// File: doc/BRIEF.md
# DDR SDRAM Bank and Power State Tracker

This block listens to the command bus of a four-bank double-data-rate SDRAM and keeps a cycle-accurate picture of the device. For each bank it knows whether the bank is idle, holds an open row, or is running a data burst. For the device as a whole it knows whether it is running, in power-down with all banks closed, or in power-down with a row held open. Commands are sampled on every rising clock edge. A bank closes when it is precharged, either on its own or with all other banks. A bank also closes by itself after a burst that asked for auto-precharge.

Sequences that a memory would reject are reported as a single-cycle violation pulse, with a reason code and the bank concerned. The block is meant to sit beside a memory controller or a bus monitor. It watches the bus and never drives it. The burst length comes from a two-bit input, not from decoding mode-register writes.

Top module: `ddr_bank_tracker`

## Requirements
- R1: A cycle with `cs_n` high is a deselect and changes no state, whatever `ras_n`, `cas_n` and `we_n` show.
- R2: Commands decode from {`ras_n`,`cas_n`,`we_n`}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 111 no-op; 110 is reserved and ignored. An activate to an idle bank `ba` sets `bank_open[ba]` after that edge and stores `addr[ROW_W-1:0]` in slice `ba` of `open_row`; other banks are untouched.
- R3: An activate to a bank that is not idle raises code 1. A read or write to an idle bank raises code 2. Neither command changes any state.
- R4: A precharge with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes all four banks, including one in a burst.
- R5: A read or write with `addr[10]` high is sampled at edge k. `bank_open[ba]` then falls after edge k+N, where N is 1, 2 or 4 for `burst_sel` 00, 01 or 10 (11 acts as 10).
- R6: A read or write with `addr[10]` low leaves the bank open after its burst ends.
- R7: A read or write to one bank ends any burst in another bank at that edge. If the ended burst had auto-precharge, its bank closes at that edge.
- R8: `pwr_state` is 00 when running, 01 in power-down with all banks closed, and 10 in power-down with a row open. `cke` sampled low while running moves to 01 if no bank is open and to 10 otherwise. `cke` sampled high in power-down returns to 00.
- R9: `cke` sampled low while running during a burst raises code 6, with `viol_bank` naming the bursting bank.
- R10: Any command other than no-op or deselect raises code 5 and is ignored when it is sampled while `pwr_state` is not 00, or while `cke` is low.
- R11: A refresh (code 3) or mode set (code 4) while any bank is open is flagged, with `viol_bank` naming the lowest-numbered open bank. With all banks idle, both are accepted silently.
- R12: Synchronous reset clears all banks, rows, power state and violation outputs. `viol_pulse` is high for exactly the cycle after each offending edge, and `viol_code` is 0 whenever it is low. For codes 1, 2 and 5, `viol_bank` is `ba`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address; bit 10 selects all-bank / auto-precharge |
| cke | input | 1 | Clock enable |
| burst_sel | input | 2 | Burst length select: 00=2, 01=4, 10/11=8 beats |
| bank_open | output | 4 | One bit per bank, set while the bank holds a row |
| open_row | output | 52 | Row per bank, bank b in bits [13b+12:13b] |
| pwr_state | output | 2 | 00 running, 01 precharge power-down, 10 active power-down |
| viol_pulse | output | 1 | One-cycle violation flag |
| viol_code | output | 3 | Violation reason, 0 when none |
| viol_bank | output | 2 | Bank tied to the violation |

## Verification
Some properties are checked on every cycle, because they follow from the previous cycle's ports alone:
- the power-down entry choice between the two power-down states;
- the rejection of commands while powered down;
- a clock-enable drop during a burst;
- the effect of an all-bank precharge;
- that no bank can open while powered down;
- that the pulse and code agree.

Other behaviour depends on history that only a scenario can build up. This covers the exact cycle on which an auto-precharge closes a bank for each burst length, the truncation of one bank's burst by a command to another, the captured row values, deselect masking, and the bank reported for refresh and mode-set conflicts. The bench's scenarios cover these.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

  localparam int CNT_W = 2;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_RSV
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_BURST = 2'd2
  } bank_st_e;

  typedef enum logic [1:0] {
    PWR_ON  = 2'd0,
    PWR_PPD = 2'd1,
    PWR_APD = 2'd2
  } pwr_e;

  typedef enum logic [2:0] {
    VC_NONE      = 3'd0,
    VC_ACT_OPEN  = 3'd1,
    VC_RW_IDLE   = 3'd2,
    VC_REF_OPEN  = 3'd3,
    VC_MRS_OPEN  = 3'd4,
    VC_PD_CMD    = 3'd5,
    VC_CKE_BURST = 3'd6
  } viol_e;

  // Pin-level command decode; chip select high masks everything.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        3'b111:  c = CMD_NOP;
        default: c = CMD_RSV;
      endcase
    end
    return c;
  endfunction

  // Clocks in a burst minus one: two beats per clock.
  function automatic logic [CNT_W-1:0] burst_last(input logic [1:0] sel);
    logic [CNT_W-1:0] r;
    case (sel)
      2'b00:   r = CNT_W'(0);
      2'b01:   r = CNT_W'(1);
      default: r = CNT_W'(3);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot
  import ddr_trk_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_open,
  input  logic             do_close,
  input  logic             do_burst,
  input  logic             do_trunc,
  input  logic             ap_in,
  input  logic [ROW_W-1:0] row_in,
  input  logic [CNT_W-1:0] last_in,
  output bank_st_e         state,
  output logic [ROW_W-1:0] row,
  output logic             burst_end
);

  logic [CNT_W-1:0] cnt;
  logic             ap;

  // Burst finishes on count exhaustion or when another bank takes the bus.
  assign burst_end = (state == BK_BURST) && !do_close && !do_burst &&
                     (do_trunc || cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BK_IDLE;
      cnt   <= '0;
      ap    <= 1'b0;
      row   <= '0;
    end else if (do_close) begin
      state <= BK_IDLE;
    end else if (do_open) begin
      state <= BK_OPEN;
      row   <= row_in;
    end else if (do_burst) begin
      state <= BK_BURST;
      cnt   <= last_in;
      ap    <= ap_in;
    end else if (burst_end) begin
      state <= ap ? BK_IDLE : BK_OPEN;
    end else if (state == BK_BURST) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/ddr_pwr_ctrl.sv
module ddr_pwr_ctrl
  import ddr_trk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic any_open,
  output pwr_e pwr,
  output logic cmd_en
);

  assign cmd_en = (pwr == PWR_ON) && cke;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr <= PWR_ON;
    end else begin
      case (pwr)
        PWR_ON:  if (!cke) pwr <= any_open ? PWR_APD : PWR_PPD;
        default: if (cke)  pwr <= PWR_ON;
      endcase
    end
  end

endmodule

// File: rtl/ddr_viol_check.sv
module ddr_viol_check
  import ddr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic                 cke,
  input  logic                 pwr_on,
  input  logic                 cmd_en,
  input  logic [NUM_BANKS-1:0] open_mask,
  input  logic [NUM_BANKS-1:0] burst_mask,
  output logic                 viol_pulse,
  output viol_e                viol_code,
  output logic [BA_W-1:0]      viol_bank
);

  function automatic logic [BA_W-1:0] lowest(input logic [NUM_BANKS-1:0] m);
    logic [BA_W-1:0] r;
    r = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (m[i]) r = BA_W'(i);
    end
    return r;
  endfunction

  viol_e           code_n;
  logic [BA_W-1:0] bank_n;

  always_comb begin
    code_n = VC_NONE;
    bank_n = ba;
    if (pwr_on && !cke && |burst_mask) begin
      code_n = VC_CKE_BURST;
      bank_n = lowest(burst_mask);
    end else if (!cmd_en) begin
      if (cmd != CMD_NOP) code_n = VC_PD_CMD;
    end else begin
      case (cmd)
        CMD_ACT: if (open_mask[ba])  code_n = VC_ACT_OPEN;
        CMD_RD,
        CMD_WR:  if (!open_mask[ba]) code_n = VC_RW_IDLE;
        CMD_REF: if (|open_mask) begin
                   code_n = VC_REF_OPEN;
                   bank_n = lowest(open_mask);
                 end
        CMD_MRS: if (|open_mask) begin
                   code_n = VC_MRS_OPEN;
                   bank_n = lowest(open_mask);
                 end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_pulse <= 1'b0;
      viol_code  <= VC_NONE;
      viol_bank  <= '0;
    end else begin
      viol_pulse <= (code_n != VC_NONE);
      viol_code  <= code_n;
      viol_bank  <= bank_n;
    end
  end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       cke,
  input  logic [1:0]                 burst_sel,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_row,
  output logic [1:0]                 pwr_state,
  output logic                       viol_pulse,
  output logic [2:0]                 viol_code,
  output logic [BA_W-1:0]            viol_bank
);

  cmd_e                 cmd_w;
  pwr_e                 pwr;
  viol_e                vcode;
  logic                 cmd_en;
  logic                 any_open;
  logic                 burst_any;
  logic                 act_go, rw_go, pre_go, all_sel;
  logic [CNT_W-1:0]     last_len;
  logic [NUM_BANKS-1:0] open_mask, burst_mask, end_mask;

  assign cmd_w    = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign last_len = burst_last(burst_sel);
  assign all_sel  = addr[AP_BIT];
  assign any_open = |open_mask;
  assign burst_any = |burst_mask;

  // Accepted command events, only while running with clock enabled.
  assign act_go = cmd_en && cmd_w == CMD_ACT && !open_mask[ba];
  assign rw_go  = cmd_en && (cmd_w == CMD_RD || cmd_w == CMD_WR) && open_mask[ba];
  assign pre_go = cmd_en && cmd_w == CMD_PRE;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_st_e st;
    logic     sel;
    assign sel = (ba == BA_W'(b));

    ddr_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .do_open  (act_go && sel),
      .do_close (pre_go && (all_sel || sel)),
      .do_burst (rw_go && sel),
      .do_trunc (rw_go && !sel),
      .ap_in    (all_sel),
      .row_in   (addr[ROW_W-1:0]),
      .last_in  (last_len),
      .state    (st),
      .row      (open_row[b*ROW_W +: ROW_W]),
      .burst_end(end_mask[b])
    );

    assign open_mask[b]  = (st != BK_IDLE);
    assign burst_mask[b] = (st == BK_BURST);
  end

  ddr_pwr_ctrl u_pwr (
    .clk     (clk),
    .rst     (rst),
    .cke     (cke),
    .any_open(any_open),
    .pwr     (pwr),
    .cmd_en  (cmd_en)
  );

  ddr_viol_check #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_viol (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd_w),
    .ba        (ba),
    .cke       (cke),
    .pwr_on    (pwr == PWR_ON),
    .cmd_en    (cmd_en),
    .open_mask (open_mask),
    .burst_mask(burst_mask),
    .viol_pulse(viol_pulse),
    .viol_code (vcode),
    .viol_bank (viol_bank)
  );

  assign bank_open = open_mask;
  assign pwr_state = pwr;
  assign viol_code = vcode;

endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cke,
  input logic                 a10,
  input logic [3:0]           cmd_pins,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [1:0]           pwr_state,
  input logic                 viol_pulse,
  input logic [2:0]           viol_code,
  input logic                 burst_any
);

  logic real_cmd;
  assign real_cmd = !cmd_pins[3] && (cmd_pins[2:0] != 3'b111);

  assert_code_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    viol_pulse == (viol_code != 3'd0));

  assert_pwr_encoding_R8: assert property (@(posedge clk) disable iff (rst)
    pwr_state != 2'b11);

  assert_ppd_entry_R8: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b00 && !cke && bank_open == '0) |=> pwr_state == 2'b01);

  assert_apd_entry_R8: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b00 && !cke && bank_open != '0) |=> pwr_state == 2'b10);

  assert_pd_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'b00 && real_cmd) |=> (viol_pulse && viol_code == 3'd5));

  assert_no_open_in_pd_R10: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'b00) |=> ((bank_open & ~$past(bank_open)) == '0));

  assert_cke_burst_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b00 && !cke && burst_any) |=> viol_code == 3'd6);

  assert_pre_all_R4: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b00 && cke && cmd_pins == 4'b0010 && a10) |=> bank_open == '0);

endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cke       (cke),
  .a10       (addr[AP_BIT]),
  .cmd_pins  ({cs_n, ras_n, cas_n, we_n}),
  .bank_open (bank_open),
  .pwr_state (pwr_state),
  .viol_pulse(viol_pulse),
  .viol_code (viol_code),
  .burst_any (burst_any)
);

// File: tb/ddr_bank_tracker_tb.sv
`timescale 1ns/1ps
module ddr_bank_tracker_tb;

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101,
                         WR = 4'b0100, PRE = 4'b0010, REF = 4'b0001,
                         MRS = 4'b0000;
  localparam logic [12:0] AP = 13'h400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        cke = 1'b1;
  logic [1:0]  burst_sel = 2'b01;
  logic [3:0]  bank_open;
  logic [51:0] open_row;
  logic [1:0]  pwr_state;
  logic        viol_pulse;
  logic [2:0]  viol_code;
  logic [1:0]  viol_bank;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ddr_bank_tracker u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cke(cke), .burst_sel(burst_sel),
    .bank_open(bank_open), .open_row(open_row), .pwr_state(pwr_state),
    .viol_pulse(viol_pulse), .viol_code(viol_code), .viol_bank(viol_bank)
  );

  typedef struct {
    string       tag;
    logic [3:0]  open;
    logic [1:0]  pwr;
    logic [2:0]  code;
    logic [1:0]  vb;
    int          rb;
    logic [12:0] rv;
  } exp_t;

  exp_t sbq[$];

  // Driver: apply one command for one edge, queue what must show after it.
  task automatic step(input logic [3:0] c, input logic [1:0] b,
                      input logic [12:0] a, input logic k,
                      input logic [3:0] eo, input logic [1:0] ep,
                      input logic [2:0] ec, input logic [1:0] evb,
                      input string tag, input int rb = -1,
                      input logic [12:0] rv = '0);
    exp_t e;
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; addr = a; cke = k;
    @(posedge clk);
    e.tag = tag; e.open = eo; e.pwr = ep; e.code = ec; e.vb = evb;
    e.rb = rb; e.rv = rv;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      logic bad;
      e = sbq.pop_front();
      checks++;
      bad = (bank_open !== e.open) || (pwr_state !== e.pwr) ||
            (viol_code !== e.code) || (viol_pulse !== (e.code != 3'd0)) ||
            (e.code != 3'd0 && viol_bank !== e.vb);
      if (bad) begin
        fails++;
        $display("FAIL %s: open=%b pwr=%0d pulse=%0d code=%0d bank=%0d expected open=%b pwr=%0d code=%0d bank=%0d",
                 e.tag, bank_open, pwr_state, viol_pulse, viol_code, viol_bank,
                 e.open, e.pwr, e.code, e.vb);
      end
      if (e.rb >= 0) begin
        checks++;
        if (open_row[e.rb*13 +: 13] !== e.rv) begin
          fails++;
          $display("FAIL %s: row[%0d]=%h expected %h", e.tag, e.rb,
                   open_row[e.rb*13 +: 13], e.rv);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(NOP, 0, 0, 1, 4'b0000, 0, 0, 0, "R12 reset state");
    step(NOP, 0, 0, 1, 4'b0000, 0, 0, 0, "R12 reset state");
    rst = 1'b0;

    // Opening and capture
    step(ACT, 0, 13'h123, 1, 4'b0001, 0, 0, 0, "R2 activate bank0", 0, 13'h123);
    step(4'b1011, 1, 13'h055, 1, 4'b0001, 0, 0, 0, "R1 deselect masks activate");
    step(ACT, 2, 13'h0AB, 1, 4'b0101, 0, 0, 0, "R2 activate bank2", 2, 13'h0AB);
    step(ACT, 0, 13'h777, 1, 4'b0101, 0, 1, 0, "R3 activate open bank", 0, 13'h123);
    step(RD, 1, 0, 1, 4'b0101, 0, 2, 1, "R3 read idle bank");

    // Bursts, BL4 = 2 clocks
    step(RD, 0, 0, 1, 4'b0101, 0, 0, 0, "R6 read no auto-precharge");
    step(NOP, 0, 0, 1, 4'b0101, 0, 0, 0, "R6 burst running");
    step(NOP, 0, 0, 1, 4'b0101, 0, 0, 0, "R6 bank stays open");
    step(WR, 2, AP, 1, 4'b0101, 0, 0, 0, "R5 write auto-precharge");
    step(NOP, 0, 0, 1, 4'b0101, 0, 0, 0, "R5 still open mid burst");
    step(NOP, 0, 0, 1, 4'b0001, 0, 0, 0, "R5 closed after BL4");

    // Precharge single and all
    step(ACT, 1, 13'h011, 1, 4'b0011, 0, 0, 0, "R2 activate bank1", 1, 13'h011);
    step(ACT, 3, 13'h1FF, 1, 4'b1011, 0, 0, 0, "R2 activate bank3", 3, 13'h1FF);
    step(PRE, 1, 0, 1, 4'b1001, 0, 0, 0, "R4 precharge one bank");
    step(PRE, 0, AP, 1, 4'b0000, 0, 0, 0, "R4 precharge all");

    // Refresh / mode set
    step(REF, 0, 0, 1, 4'b0000, 0, 0, 0, "R11 refresh all idle");
    step(ACT, 3, 13'h002, 1, 4'b1000, 0, 0, 0, "R2 activate bank3");
    step(REF, 0, 0, 1, 4'b1000, 0, 3, 3, "R11 refresh with open bank");
    step(MRS, 1, 0, 1, 4'b1000, 0, 4, 3, "R11 mode set with open bank");

    // Power-down
    step(NOP, 0, 0, 0, 4'b1000, 2, 0, 0, "R8 active power-down");
    step(NOP, 0, 0, 0, 4'b1000, 2, 0, 0, "R8 stays powered down");
    step(ACT, 0, 0, 0, 4'b1000, 2, 5, 0, "R10 command in power-down");
    step(ACT, 0, 0, 1, 4'b1000, 0, 5, 0, "R10 command on exit edge");
    step(NOP, 0, 0, 1, 4'b1000, 0, 0, 0, "R8 running");
    step(PRE, 0, AP, 1, 4'b0000, 0, 0, 0, "R4 precharge all");
    step(NOP, 0, 0, 0, 4'b0000, 1, 0, 0, "R8 precharge power-down");
    step(NOP, 0, 0, 1, 4'b0000, 0, 0, 0, "R8 exit power-down");
    step(ACT, 3, 0, 0, 4'b0000, 1, 5, 3, "R10 command with cke low");
    step(NOP, 0, 0, 1, 4'b0000, 0, 0, 0, "R8 exit power-down");

    // Clock enable drop during burst
    step(ACT, 1, 13'h0F0, 1, 4'b0010, 0, 0, 0, "R2 activate bank1", 1, 13'h0F0);
    step(RD, 1, 0, 1, 4'b0010, 0, 0, 0, "R9 start burst");
    step(NOP, 0, 0, 0, 4'b0010, 2, 6, 1, "R9 cke drop in burst");
    step(NOP, 0, 0, 1, 4'b0010, 0, 0, 0, "R9 recover");

    // Truncation
    step(ACT, 2, 13'h0C3, 1, 4'b0110, 0, 0, 0, "R2 activate bank2", 2, 13'h0C3);
    step(RD, 1, AP, 1, 4'b0110, 0, 0, 0, "R7 read bank1 auto-precharge");
    step(RD, 2, 0, 1, 4'b0100, 0, 0, 0, "R7 bank1 burst cut, closes");
    step(NOP, 0, 0, 1, 4'b0100, 0, 0, 0, "R7 bank2 burst");
    step(NOP, 0, 0, 1, 4'b0100, 0, 0, 0, "R6 bank2 open");

    // BL8
    burst_sel = 2'b10;
    step(RD, 2, AP, 1, 4'b0100, 0, 0, 0, "R5 BL8 start");
    step(NOP, 0, 0, 1, 4'b0100, 0, 0, 0, "R5 BL8 clock2");
    step(NOP, 0, 0, 1, 4'b0100, 0, 0, 0, "R5 BL8 clock3");
    step(NOP, 0, 0, 1, 4'b0100, 0, 0, 0, "R5 BL8 clock4");
    step(NOP, 0, 0, 1, 4'b0000, 0, 0, 0, "R5 BL8 closed");

    // BL2
    burst_sel = 2'b00;
    step(ACT, 0, 13'h0AA, 1, 4'b0001, 0, 0, 0, "R2 activate bank0", 0, 13'h0AA);
    step(WR, 0, AP, 1, 4'b0001, 0, 0, 0, "R5 BL2 start");
    step(NOP, 0, 0, 1, 4'b0000, 0, 0, 0, "R5 BL2 closed");

    // Mid-run reset
    step(ACT, 1, 13'h033, 1, 4'b0010, 0, 0, 0, "R2 activate bank1");
    rst = 1'b1;
    step(NOP, 0, 0, 1, 4'b0000, 0, 0, 0, "R12 reset clears banks", 1, 13'h000);
    rst = 1'b0;

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule